// File: doc/BRIEF.md
# Two-Channel Demand-Paced DMA Controller

This block sequences a two-channel DMA engine in which each channel can be paced by an external peripheral. Software loads a channel with a start address, a length in 32-bit words and a pacing choice, then pulses a start strobe. A demand-paced channel moves data only while its active-low request line is held low. A free-running channel moves data as soon as it wins arbitration. Words are taken from a ready/valid source port. Each word is written out on a local bus that is 8, 16 or 32 bits wide, so one word takes four, two or one local cycles.

A single engine serves one channel at a time. While a local cycle serves a demand-paced channel, that channel's active-low acknowledge is driven low. Once a word has started, all of its narrow cycles finish even if the request is withdrawn part way through. After the last word a per-channel done flag is set, and the next accepted start clears it. When both channels are ready together, a programmable mode decides which one goes first: channel 0 always, channel 1 always, or rotating, where the channel whose burst ended most recently loses.

Top module: `dmd_dma_ctrl`

## Requirements
- R1: During and right after reset, `lcl_cyc` and `src_ready` are 0, `dack_n` is 2'b11 and `done` is 2'b00.
- R2: A start strobe (`cfg_start`) aimed at channel `cfg_chan` loads that channel's address, word count and pacing flag (`cfg_demand`=1 means demand-paced) only if the channel is not busy. A start aimed at a busy channel is ignored and changes neither its address nor its remaining count.
- R3: A busy demand-paced channel can be granted only while its `dreq_n` bit is 0. A busy free-running channel can be granted whatever `dreq_n` holds. An idle channel is never granted.
- R4: `dack_n[c]` is 0 exactly on the local cycles (`lcl_cyc`=1) that serve demand-paced channel c. It is never 0 for a free-running channel, and at most one bit is 0 at a time.
- R5: `lbus_width` 0 selects 8 bits (four cycles per word), 1 selects 16 bits (two cycles) and 2 or 3 selects 32 bits (one cycle). Lanes go out least significant first on the low bits of `lcl_data`, with the unused upper bits at 0. `lcl_addr` starts at the loaded address and advances by the lane size in bytes on every local cycle. Both outputs read 0 when no cycle is in progress.
- R6: If `dreq_n` rises part way through a word, the remaining narrow cycles of that word still complete. The channel then releases the bus and moves nothing more until its request returns.
- R7: After the channel's last word, `done[c]` is 1 and the channel stops. A start with a word count of 0 sets `done[c]` at once and moves no data.
- R8: An accepted start clears `done[c]` for that channel.
- R9: When both channels are eligible in the same cycle, the winner is set by `prio_mode`: 0 gives channel 0, 1 gives channel 1, and 2 or 3 gives the channel other than the one whose burst ended last. After reset, channel 1 counts as the last one served.
- R10: Once granted, a channel keeps the engine word after word, without rearbitration, for as long as it stays eligible when each word's last cycle occurs. Its burst ends when it is no longer eligible at that point or when its count runs out.
- R11: `src_ready` is 1 only in the fetch step before each word, never in the same cycle as `lcl_cyc`. It stays 1 until `src_valid` is seen, and the word on `src_data` in that cycle is the one sent out next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | One-cycle start strobe for channel `cfg_chan` |
| cfg_chan | input | 1 | Channel that the start strobe addresses |
| cfg_demand | input | 1 | 1 = demand-paced, 0 = free-running |
| cfg_addr | input | AW | Start address on the local bus |
| cfg_words | input | CW | Transfer length in 32-bit words |
| prio_mode | input | 2 | 0 ch0 first, 1 ch1 first, 2/3 rotating |
| lbus_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit local bus |
| dreq_n | input | 2 | Per-channel request, active low |
| dack_n | output | 2 | Per-channel acknowledge, active low |
| src_valid | input | 1 | Source word available |
| src_data | input | 32 | Source word |
| src_ready | output | 1 | Engine is taking a source word |
| lcl_cyc | output | 1 | Local write cycle in progress |
| lcl_addr | output | AW | Local bus byte address |
| lcl_data | output | 32 | Local bus data, lane in the low bits |
| done | output | 2 | Per-channel terminal-count flag |

## Verification
The bound checker watches the cycle-level properties on every cycle. These are the one-hot acknowledge that appears only during a local cycle, source-ready never overlapping a local cycle and holding through a stall, a word's narrow cycles running without a gap, the address stepping by the lane size, clean upper bits on narrow lanes, and done following terminal count. Some behaviours depend on history across many cycles, and only the bench's scenarios can show them. These are which channel wins under each priority mode and after a rotation, the ignored start on a busy channel, the exact word count moved after a request is withdrawn mid-word, and the zero-length start and restart of done. The bench checks them against its behavioural model and a few counted totals.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_MOVE  = 2'd2
  } eng_state_t;

  localparam logic [1:0] PRIO_CH0 = 2'd0;
  localparam logic [1:0] PRIO_CH1 = 2'd1;

  // bytes carried by one local cycle for a width code
  function automatic logic [2:0] beat_bytes(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // index of the final narrow cycle of a word
  function automatic logic [1:0] last_beat_idx(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // lane of the word presented on the bus, low bits, upper bits cleared
  function automatic logic [31:0] lane_out(input logic [31:0] w,
                                           input logic [1:0]  wsel,
                                           input logic [1:0]  idx);
    logic [31:0] sh;
    case (wsel)
      2'd0: begin
        sh = w >> {idx, 3'b000};
        return {24'd0, sh[7:0]};
      end
      2'd1: begin
        sh = w >> {idx[0], 4'b0000};
        return {16'd0, sh[15:0]};
      end
      default: return w;
    endcase
  endfunction

  // winner between two channels given the mode and last served channel
  function automatic logic pick_chan(input logic [1:0] req,
                                     input logic [1:0] mode,
                                     input logic       last_served);
    if (!req[1]) return 1'b0;
    if (!req[0]) return 1'b1;
    case (mode)
      PRIO_CH0: return 1'b0;
      PRIO_CH1: return 1'b1;
      default:  return ~last_served;
    endcase
  endfunction

endpackage

// File: rtl/dmd_chan_regs.sv
module dmd_chan_regs
  import dmd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter bit CH_ID = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_chan,
  input  logic          cfg_demand,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_words,
  input  logic          adv,
  input  logic [2:0]    adv_bytes,
  input  logic          word_dec,
  output logic          busy,
  output logic          demand,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic          last_word
);

  logic [CW-1:0] words_left;
  logic          take;

  assign take      = cfg_start && (cfg_chan == CH_ID) && !busy;
  assign last_word = (words_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      demand     <= 1'b0;
      addr       <= '0;
      done       <= 1'b0;
      words_left <= '0;
    end else if (take) begin
      addr       <= cfg_addr;
      words_left <= cfg_words;
      demand     <= cfg_demand;
      done       <= (cfg_words == '0);
      busy       <= (cfg_words != '0);
    end else begin
      if (adv) begin
        addr <= addr + AW'(adv_bytes);
      end
      if (word_dec) begin
        words_left <= words_left - CW'(1);
        if (last_word) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dmd_arbiter.sv
module dmd_arbiter
  import dmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] mode,
  input  logic       burst_end,
  input  logic       burst_ch,
  output logic       gnt_any,
  output logic       gnt_ch,
  output logic       last_served
);

  assign gnt_any = |req;
  assign gnt_ch  = pick_chan(req, mode, last_served);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_served <= 1'b1;
    end else if (burst_end) begin
      last_served <= burst_ch;
    end
  end

endmodule

// File: rtl/dmd_beat_engine.sv
module dmd_beat_engine
  import dmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gnt_any,
  input  logic        gnt_ch,
  input  logic        src_valid,
  input  logic [31:0] src_data,
  input  logic [1:0]  width_sel,
  input  logic        cur_eligible,
  input  logic        cur_last_word,
  output logic        src_ready,
  output logic        move,
  output logic        cur_ch,
  output logic        beat_last,
  output logic        tc_hit,
  output logic        burst_end,
  output logic [31:0] lane_data
);

  eng_state_t  st;
  logic [31:0] word_q;
  logic [1:0]  beat_idx;

  assign move      = (st == ENG_MOVE);
  assign src_ready = (st == ENG_FETCH);
  assign beat_last = move && (beat_idx == last_beat_idx(width_sel));
  assign tc_hit    = beat_last && cur_last_word;
  assign burst_end = beat_last && (cur_last_word || !cur_eligible);
  assign lane_data = move ? lane_out(word_q, width_sel, beat_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ENG_IDLE;
      cur_ch   <= 1'b0;
      word_q   <= '0;
      beat_idx <= '0;
    end else begin
      case (st)
        ENG_IDLE: begin
          if (gnt_any) begin
            st     <= ENG_FETCH;
            cur_ch <= gnt_ch;
          end
        end
        ENG_FETCH: begin
          if (src_valid) begin
            st       <= ENG_MOVE;
            word_q   <= src_data;
            beat_idx <= '0;
          end
        end
        ENG_MOVE: begin
          if (beat_last) begin
            st <= burst_end ? ENG_IDLE : ENG_FETCH;
          end else begin
            beat_idx <= beat_idx + 2'd1;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dmd_dma_ctrl.sv
module dmd_dma_ctrl
  import dmd_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_chan,
  input  logic          cfg_demand,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_words,
  input  logic [1:0]    prio_mode,
  input  logic [1:0]    lbus_width,
  input  logic [1:0]    dreq_n,
  output logic [1:0]    dack_n,
  input  logic          src_valid,
  input  logic [31:0]   src_data,
  output logic          src_ready,
  output logic          lcl_cyc,
  output logic [AW-1:0] lcl_addr,
  output logic [31:0]   lcl_data,
  output logic [1:0]    done
);

  localparam int NCH = 2;

  logic [NCH-1:0] busy;
  logic [NCH-1:0] demand;
  logic [NCH-1:0] last_word;
  logic [NCH-1:0] eligible;
  logic [AW-1:0]  addr_q [NCH];

  logic cur_ch;
  logic beat_last;
  logic tc_hit;
  logic burst_end;
  logic gnt_any;
  logic gnt_ch;
  logic last_served;
  logic [2:0] step_bytes;

  assign step_bytes = beat_bytes(lbus_width);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic serving;
    assign serving     = lcl_cyc && (cur_ch == 1'(g));
    assign eligible[g] = busy[g] && (!demand[g] || !dreq_n[g]);
    assign dack_n[g]   = !(serving && demand[g]);

    dmd_chan_regs #(.AW(AW), .CW(CW), .CH_ID(1'(g))) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_start  (cfg_start),
      .cfg_chan   (cfg_chan),
      .cfg_demand (cfg_demand),
      .cfg_addr   (cfg_addr),
      .cfg_words  (cfg_words),
      .adv        (serving),
      .adv_bytes  (step_bytes),
      .word_dec   (serving && beat_last),
      .busy       (busy[g]),
      .demand     (demand[g]),
      .addr       (addr_q[g]),
      .done       (done[g]),
      .last_word  (last_word[g])
    );
  end

  dmd_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (eligible),
    .mode        (prio_mode),
    .burst_end   (burst_end),
    .burst_ch    (cur_ch),
    .gnt_any     (gnt_any),
    .gnt_ch      (gnt_ch),
    .last_served (last_served)
  );

  dmd_beat_engine u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .gnt_any       (gnt_any),
    .gnt_ch        (gnt_ch),
    .src_valid     (src_valid),
    .src_data      (src_data),
    .width_sel     (lbus_width),
    .cur_eligible  (eligible[cur_ch]),
    .cur_last_word (last_word[cur_ch]),
    .src_ready     (src_ready),
    .move          (lcl_cyc),
    .cur_ch        (cur_ch),
    .beat_last     (beat_last),
    .tc_hit        (tc_hit),
    .burst_end     (burst_end),
    .lane_data     (lcl_data)
  );

  assign lcl_addr = lcl_cyc ? addr_q[cur_ch] : '0;

endmodule

// File: rtl/dmd_dma_chk.sv
module dmd_dma_chk
  import dmd_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lcl_cyc,
  input logic [1:0]    lbus_width,
  input logic [AW-1:0] lcl_addr,
  input logic [31:0]   lcl_data,
  input logic [1:0]    dack_n,
  input logic          src_ready,
  input logic          src_valid,
  input logic [1:0]    done,
  input logic          beat_last,
  input logic          tc_hit,
  input logic          cur_ch
);

  p_dack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  p_dack_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != 2'b11) |-> lcl_cyc);

  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !lcl_cyc);

  p_ready_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !src_valid) |=> src_ready);

  p_word_finishes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_cyc && !beat_last) |=> (lcl_cyc && $stable(cur_ch)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_cyc && $past(lcl_cyc) && $stable(lbus_width))
      |-> (lcl_addr == $past(lcl_addr) + AW'(beat_bytes(lbus_width))));

  p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_cyc && lbus_width == 2'd0) |-> (lcl_data[31:8] == 24'd0));

  p_tc_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> done[$past(cur_ch)]);

  p_word_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !lcl_cyc);

endmodule

bind dmd_dma_ctrl dmd_dma_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dmd_dma_ctrl.sv
module sim_dmd_dma_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_start = 1'b0;
  logic          cfg_chan = 1'b0;
  logic          cfg_demand = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_words = '0;
  logic [1:0]    prio_mode = 2'd0;
  logic [1:0]    lbus_width = 2'd0;
  logic [1:0]    dreq_n = 2'b11;
  logic [1:0]    dack_n;
  logic          src_valid = 1'b0;
  logic [31:0]   src_data = '0;
  logic          src_ready;
  logic          lcl_cyc;
  logic [AW-1:0] lcl_addr;
  logic [31:0]   lcl_data;
  logic [1:0]    done;

  dmd_dma_ctrl #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_chan(cfg_chan),
    .cfg_demand(cfg_demand), .cfg_addr(cfg_addr), .cfg_words(cfg_words),
    .prio_mode(prio_mode), .lbus_width(lbus_width), .dreq_n(dreq_n),
    .dack_n(dack_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .lcl_cyc(lcl_cyc), .lcl_addr(lcl_addr),
    .lcl_data(lcl_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    cmp_en   = 0;
  string scen     = "R1";
  int    dreq_mode [2] = '{0, 0};   // 0 high, 1 low, 2 random
  bit    src_always = 1;
  logic [31:0] rng = 32'h1234_5678;
  int    cyc_count = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h", req, scen, what, act, exp);
    end
  endtask

  // stimulus source: data, valid and request lines
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      src_data  = rng;
      src_valid = src_always | rng[4];
      for (int c = 0; c < 2; c++) begin
        if (dreq_mode[c] == 0)      dreq_n[c] = 1'b1;
        else if (dreq_mode[c] == 1) dreq_n[c] = 1'b0;
        else                        dreq_n[c] = rng[10+c] & rng[12+c];
      end
    end
  end

  // behavioural reference model
  int          m_ph;        // 0 waiting, 1 taking a word, 2 writing lanes
  int          m_ch;
  int          m_idx;
  int          m_last;
  logic [31:0] m_word;
  int          m_rem  [2];
  logic [31:0] m_addr [2];
  bit          m_busy [2];
  bit          m_dem  [2];
  bit          m_done [2];

  function automatic int nbeats(input logic [1:0] w);
    if (w == 2'd0) return 4;
    if (w == 2'd1) return 2;
    return 1;
  endfunction

  function automatic bit m_elig(input int c);
    return m_busy[c] && (!m_dem[c] || dreq_n[c] == 1'b0);
  endfunction

  always @(posedge clk) begin
    bit st_ok;
    int st_c;
    bit e0;
    bit e1;
    if (!rst_n) begin
      m_ph = 0; m_ch = 0; m_idx = 0; m_last = 1; m_word = '0;
      for (int c = 0; c < 2; c++) begin
        m_rem[c] = 0; m_addr[c] = '0; m_busy[c] = 0; m_dem[c] = 0; m_done[c] = 0;
      end
    end else begin
      st_c  = int'(cfg_chan);
      st_ok = cfg_start && !m_busy[st_c];
      if (m_ph == 0) begin
        e0 = m_elig(0);
        e1 = m_elig(1);
        if (e0 || e1) begin
          if (e0 && e1) m_ch = (prio_mode == 0) ? 0 : (prio_mode == 1) ? 1 : 1 - m_last;
          else          m_ch = e0 ? 0 : 1;
          m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (src_valid) begin
          m_word = src_data;
          m_idx  = 0;
          m_ph   = 2;
        end
      end else begin
        m_addr[m_ch] = m_addr[m_ch] + 32'(4 / nbeats(lbus_width));
        m_idx++;
        if (m_idx == nbeats(lbus_width)) begin
          m_rem[m_ch]--;
          if (m_rem[m_ch] == 0) begin
            m_busy[m_ch] = 0; m_done[m_ch] = 1; m_last = m_ch; m_ph = 0;
          end else if (m_elig(m_ch)) begin
            m_ph = 1;
          end else begin
            m_last = m_ch; m_ph = 0;
          end
        end
      end
      if (st_ok) begin
        m_addr[st_c] = cfg_addr;
        m_rem[st_c]  = int'(cfg_words);
        m_dem[st_c]  = cfg_demand;
        m_done[st_c] = (cfg_words == 0);
        m_busy[st_c] = (cfg_words != 0);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [31:0] e_data;
    logic [31:0] e_addr;
    logic [1:0]  e_dack;
    logic [63:0] mask;
    int          bits;
    if (cmp_en) begin
      bits   = 32 / nbeats(lbus_width);
      mask   = (64'd1 << bits) - 64'd1;
      e_data = (m_ph == 2) ? 32'((m_word >> (m_idx * bits)) & mask) : 32'd0;
      e_addr = (m_ph == 2) ? m_addr[m_ch] : 32'd0;
      for (int c = 0; c < 2; c++)
        e_dack[c] = !(m_ph == 2 && m_ch == c && m_dem[c]);
      chk(lcl_cyc == (m_ph == 2), "R3", "lcl_cyc", 64'(lcl_cyc), 64'(m_ph == 2));
      chk(src_ready == (m_ph == 1), "R11", "src_ready", 64'(src_ready), 64'(m_ph == 1));
      chk(lcl_data == e_data, "R5", "lcl_data", 64'(lcl_data), 64'(e_data));
      chk(lcl_addr == e_addr, "R5", "lcl_addr", 64'(lcl_addr), 64'(e_addr));
      chk(dack_n == e_dack, "R4", "dack_n", 64'(dack_n), 64'(e_dack));
      chk(done == {m_done[1], m_done[0]}, "R7", "done", 64'(done),
          64'({m_done[1], m_done[0]}));
      if (lcl_cyc) cyc_count++;
    end
  end

  task automatic start_ch(input bit ch, input bit dem, input logic [AW-1:0] a,
                          input int words);
    @(posedge clk);
    #1;
    cfg_start  = 1'b1;
    cfg_chan   = ch;
    cfg_demand = dem;
    cfg_addr   = a;
    cfg_words  = CW'(words);
    @(posedge clk);
    #1;
    cfg_start  = 1'b0;
  endtask

  task automatic wait_model_done(input int ch, input string req);
    int n = 0;
    while (!m_done[ch] && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(m_done[ch] == 1, req, "completion in time", 64'(m_done[ch]), 64'd1);
  endtask

  task automatic wait_first_cycle();
    int n = 0;
    @(negedge clk);
    while (!lcl_cyc && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (%s): actual running expected finished", scen);
    summary();
  end

  initial begin
    // R1: reset state
    @(posedge clk);
    @(negedge clk);
    chk(lcl_cyc == 0 && src_ready == 0, "R1", "cyc/ready in reset",
        64'({lcl_cyc, src_ready}), 64'd0);
    chk(dack_n == 2'b11, "R1", "dack_n in reset", 64'(dack_n), 64'd3);
    chk(done == 2'b00, "R1", "done in reset", 64'(done), 64'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_en = 1;

    // R3 / R10: demand channel waits for request, then bursts on 8-bit bus
    scen = "R3";
    lbus_width = 2'd0;
    start_ch(1'b0, 1'b1, 32'h0000_1000, 3);
    repeat (8) @(negedge clk);
    chk(lcl_cyc == 0, "R3", "no cycle without request", 64'(lcl_cyc), 64'd0);
    scen = "R10";
    cyc_count = 0;
    dreq_mode[0] = 1;
    wait_model_done(0, "R10");
    chk(cyc_count == 12, "R10", "narrow cycles for 3 words", 64'(cyc_count), 64'd12);
    dreq_mode[0] = 0;

    // R4: free-running channel on 16-bit bus, no acknowledge
    scen = "R4";
    lbus_width = 2'd1;
    start_ch(1'b1, 1'b0, 32'h0000_8000, 2);
    wait_model_done(1, "R4");

    // R8, R6, R2: restart, withdraw request mid-word, start while busy
    scen = "R8";
    lbus_width = 2'd0;
    start_ch(1'b0, 1'b1, 32'h0000_2000, 4);
    @(negedge clk);
    chk(done[0] == 1'b0, "R8", "done cleared by start", 64'(done[0]), 64'd0);
    scen = "R6";
    cyc_count = 0;
    dreq_mode[0] = 1;
    wait_first_cycle();
    dreq_mode[0] = 0;
    repeat (12) @(negedge clk);
    chk(cyc_count == 4, "R6", "cycles after mid-word withdraw", 64'(cyc_count), 64'd4);
    scen = "R2";
    start_ch(1'b0, 1'b1, 32'h0000_9990, 1);
    dreq_mode[0] = 1;
    wait_model_done(0, "R2");
    chk(cyc_count == 16, "R2", "busy start ignored, total cycles", 64'(cyc_count), 64'd16);
    dreq_mode[0] = 0;

    // R9: fixed priorities on 32-bit bus
    scen = "R9";
    lbus_width = 2'd2;
    prio_mode  = 2'd1;
    start_ch(1'b0, 1'b1, 32'h0000_1000, 2);
    start_ch(1'b1, 1'b1, 32'h0000_8000, 2);
    dreq_mode[0] = 1;
    dreq_mode[1] = 1;
    wait_first_cycle();
    chk(lcl_addr[15] == 1'b1, "R9", "mode 1 serves channel 1 first", 64'(lcl_addr), 64'h8000);
    wait_model_done(0, "R9");
    wait_model_done(1, "R9");
    dreq_mode[0] = 0;
    dreq_mode[1] = 0;
    prio_mode = 2'd0;
    start_ch(1'b0, 1'b1, 32'h0000_1000, 2);
    start_ch(1'b1, 1'b1, 32'h0000_8000, 2);
    dreq_mode[0] = 1;
    dreq_mode[1] = 1;
    wait_first_cycle();
    chk(lcl_addr[15] == 1'b0, "R9", "mode 0 serves channel 0 first", 64'(lcl_addr), 64'h1000);
    wait_model_done(0, "R9");
    wait_model_done(1, "R9");

    // R9 / R11: rotating priority, random requests and source stalls
    scen = "R11";
    dreq_mode[0] = 2;
    dreq_mode[1] = 2;
    src_always = 0;
    prio_mode  = 2'd2;
    lbus_width = 2'd1;
    start_ch(1'b0, 1'b1, 32'h0000_3000, 8);
    start_ch(1'b1, 1'b1, 32'h0000_A000, 8);
    wait_model_done(0, "R9");
    wait_model_done(1, "R11");
    dreq_mode[0] = 0;
    dreq_mode[1] = 0;
    src_always = 1;

    // R7 / R8: zero-length start, then restart
    scen = "R7";
    start_ch(1'b1, 1'b1, 32'h0000_0100, 0);
    @(negedge clk);
    chk(done[1] == 1'b1, "R7", "zero-length sets done", 64'(done[1]), 64'd1);
    scen = "R8";
    start_ch(1'b1, 1'b1, 32'h0000_0100, 1);
    @(negedge clk);
    chk(done[1] == 1'b0, "R8", "restart clears done", 64'(done[1]), 64'd0);
    dreq_mode[1] = 1;
    wait_model_done(1, "R7");
    dreq_mode[1] = 0;
    repeat (4) @(negedge clk);

    summary();
  end

endmodule